// File: doc/BRIEF.md
# Frame-Aligned Triggered Capture

This block sits between a four-lane channelizer output and a banked frame buffer. Each input beat carries one sample per lane, a valid bit and a start-of-frame marker. While the block is idle nothing reaches the buffer. A one-cycle trigger pulse arms it. From then on it waits for the next beat on which start-of-frame and valid are both high, so a capture always begins at bin 0 of a frame.

From that beat on it forwards exactly `BEATS` valid beats to the buffer as a gated write strobe with the matching data. A frame-end flag marks the final forwarded beat. It then spends one cycle in a completion state and returns to idle until it is triggered again. Beats with valid low are neither forwarded nor counted. A start-of-frame that arrives in the middle of a capture sets a sticky error flag, and the capture still completes its full count.

Outputs are registered. A forwarded beat appears on the write port one clock after it is presented at the input. The reset input is asynchronous and active low. Internally its release is synchronized to the clock.

Top module: `frame_capture`

## Requirements
- R1: While reset is applied and after it is released, `busy_o`, `wr_valid_o`, `frame_end_o` and `frame_err_o` are all 0.
- R2: A trigger pulse seen while idle makes `busy_o` high from the next clock edge, and `busy_o` rises for no other reason.
- R3: While armed, a beat is not forwarded unless both `in_valid_i` and `in_sof_i` are high. This covers valid beats without start-of-frame and start-of-frame with valid low.
- R4: The first forwarded beat is the armed beat on which `in_valid_i` and `in_sof_i` are both high.
- R5: One capture forwards exactly `BEATS` beats. Cycles with `in_valid_i` low are neither forwarded nor counted. `wr_valid_o` is high only while `busy_o` is high.
- R6: `frame_end_o` is high together with `wr_valid_o` on the last forwarded beat of a capture, and on no other cycle.
- R7: `busy_o` stays high for the single cycle in which the frame-end beat is presented, then goes low. No further beat is forwarded until the next trigger, even if complete frames arrive.
- R8: A trigger pulse while armed, capturing or in the completion cycle has no effect: the capture length is unchanged and the block returns to idle.
- R9: A beat with `in_valid_i` and `in_sof_i` high during a capture sets `frame_err_o`. The flag stays set until reset, and the capture still forwards `BEATS` beats.
- R10: `wr_data_o` equals the `in_data_i` of the forwarded beat, lane for lane, one clock after that beat is presented. Lane `l` occupies bits `[l*SAMPLE_W +: SAMPLE_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_i | input | 1 | One-cycle capture request |
| in_valid_i | input | 1 | Input beat valid |
| in_sof_i | input | 1 | Input beat holds bins 0..LANES-1 of a frame |
| in_data_i | input | LANES*SAMPLE_W | Lane samples of the input beat |
| wr_valid_o | output | 1 | Write strobe to the banked buffer |
| wr_data_o | output | LANES*SAMPLE_W | Registered lane samples of the forwarded beat |
| frame_end_o | output | 1 | Marks the last forwarded beat of a capture |
| busy_o | output | 1 | High in every state except idle |
| frame_err_o | output | 1 | Sticky flag: start-of-frame seen during a capture |

## Verification
The bench sweeps a small configuration through every combination of gap density and armed-phase noise. Gaps range from no invalid cycles inside the frame to an invalid cycle after every beat. Noise consists of valid beats without start-of-frame and of start-of-frame beats with valid low. The gap patterns distinguish counting valid beats from counting cycles. The noise distinguishes a start gated on both markers from a start on either marker alone. Separate runs place trigger pulses in the armed, capturing and completion states, insert a start-of-frame in mid-capture, and send a whole frame after completion to show that no capture starts without a fresh trigger.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_CAPTURE = 2'd2,
    ST_DONE    = 2'd3
  } cap_state_e;
endpackage

// File: rtl/cap_rst_sync.sv
// Asynchronous assertion, synchronous release of the active-low reset.
module cap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/cap_beat_cnt.sv
// Counts accepted beats of one capture; flags the final one.
module cap_beat_cnt #(
  parameter int BEATS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = (BEATS > 2) ? $clog2(BEATS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(BEATS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = start_i | inc_i;
  assign last_o = (cnt_q == LAST_IDX);

  always_comb begin
    if (start_i)     cnt_d = CW'(1);
    else if (last_o) cnt_d = '0;
    else             cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cap_ctrl.sv
// Capture sequencer: idle -> armed -> capturing -> done -> idle.
module cap_ctrl
  import cap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic in_valid_i,
  input  logic in_sof_i,
  input  logic last_i,
  output logic start_o,
  output logic inc_o,
  output logic fin_o,
  output logic busy_o,
  output logic err_o
);
  cap_state_e st_q, st_d;
  logic       err_q, err_d;

  always_comb begin
    st_d    = st_q;
    start_o = 1'b0;
    inc_o   = 1'b0;
    fin_o   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (trig_i) st_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (in_valid_i && in_sof_i) begin
          start_o = 1'b1;
          st_d    = ST_CAPTURE;
        end
      end
      ST_CAPTURE: begin
        if (in_valid_i) begin
          inc_o = 1'b1;
          if (last_i) begin
            fin_o = 1'b1;
            st_d  = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  assign err_d = err_q | ((st_q == ST_CAPTURE) & in_valid_i & in_sof_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign err_o  = err_q;
endmodule

// File: rtl/cap_out_stage.sv
// Registered write port toward the banked buffer, one register per lane.
module cap_out_stage #(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 50
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      accept_i,
  input  logic                      fin_i,
  input  logic [LANES*SAMPLE_W-1:0] data_i,
  output logic                      wr_valid_o,
  output logic                      frame_end_o,
  output logic [LANES*SAMPLE_W-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid_o  <= 1'b0;
      frame_end_o <= 1'b0;
    end else begin
      wr_valid_o  <= accept_i;
      frame_end_o <= fin_i;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SAMPLE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lane_q <= '0;
      else if (accept_i) lane_q <= data_i[l*SAMPLE_W +: SAMPLE_W];
    end
    assign data_o[l*SAMPLE_W +: SAMPLE_W] = lane_q;
  end
endmodule

// File: rtl/frame_capture.sv
// Triggered, frame-aligned capture of one channelizer frame. BEATS >= 2.
module frame_capture #(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 50,
  parameter int BEATS    = 128
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      trig_i,
  input  logic                      in_valid_i,
  input  logic                      in_sof_i,
  input  logic [LANES*SAMPLE_W-1:0] in_data_i,
  output logic                      wr_valid_o,
  output logic [LANES*SAMPLE_W-1:0] wr_data_o,
  output logic                      frame_end_o,
  output logic                      busy_o,
  output logic                      frame_err_o
);
  logic srst_n;
  logic start, inc, fin, last;

  cap_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cap_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (srst_n),
    .trig_i     (trig_i),
    .in_valid_i (in_valid_i),
    .in_sof_i   (in_sof_i),
    .last_i     (last),
    .start_o    (start),
    .inc_o      (inc),
    .fin_o      (fin),
    .busy_o     (busy_o),
    .err_o      (frame_err_o)
  );

  cap_beat_cnt #(.BEATS(BEATS)) u_cnt (
    .clk     (clk),
    .rst_n   (srst_n),
    .start_i (start),
    .inc_i   (inc),
    .last_o  (last)
  );

  cap_out_stage #(.LANES(LANES), .SAMPLE_W(SAMPLE_W)) u_out (
    .clk         (clk),
    .rst_n       (srst_n),
    .accept_i    (start | inc),
    .fin_i       (fin),
    .data_i      (in_data_i),
    .wr_valid_o  (wr_valid_o),
    .frame_end_o (frame_end_o),
    .data_o      (wr_data_o)
  );
endmodule

// File: rtl/cap_chk.sv
module cap_chk (
  input logic clk,
  input logic rst_n,
  input logic trig_i,
  input logic in_valid_i,
  input logic wr_valid_o,
  input logic frame_end_o,
  input logic busy_o,
  input logic frame_err_o
);
  // R6
  fe_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |-> wr_valid_o);

  // R2
  arm_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(trig_i));

  // R5
  write_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> busy_o);

  // R5
  write_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> $past(in_valid_i));

  // R7
  idle_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(frame_end_o));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |=> frame_err_o);
endmodule

bind frame_capture cap_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trig_i      (trig_i),
  .in_valid_i  (in_valid_i),
  .wr_valid_o  (wr_valid_o),
  .frame_end_o (frame_end_o),
  .busy_o      (busy_o),
  .frame_err_o (frame_err_o)
);

// File: tb/sim_frame_capture.sv
`timescale 1ns/1ps
module sim_frame_capture;
  localparam int CLK_P = 10;
  localparam int LANES = 4;
  localparam int SW    = 8;
  localparam int BEATS = 8;
  localparam int DW    = LANES * SW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig = 1'b0, vld = 1'b0, sof = 1'b0;
  logic [DW-1:0] din = '0;
  logic          wr_valid, frame_end, busy, frame_err;
  logic [DW-1:0] wr_data;

  int nvec = 0, nbad = 0, ncap = 0, nfe = 0;
  logic [DW-1:0] cap_d [64];
  logic          cap_fe [64];
  logic          s_busy, s_fe;
  bit            finished = 0;

  always #(CLK_P/2) clk = ~clk;

  frame_capture #(.LANES(LANES), .SAMPLE_W(SW), .BEATS(BEATS)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .in_valid_i(vld), .in_sof_i(sof),
    .in_data_i(din), .wr_valid_o(wr_valid), .wr_data_o(wr_data),
    .frame_end_o(frame_end), .busy_o(busy), .frame_err_o(frame_err));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] beat_word(input int tag, input int k);
    logic [DW-1:0] w;
    for (int l = 0; l < LANES; l++) w[l*SW +: SW] = SW'(tag*32 + 4*k + l);
    return w;
  endfunction

  // Sample what the last edge produced, then drive the next beat.
  task automatic step(input logic v, input logic s, input logic t, input logic [DW-1:0] d);
    @(negedge clk);
    if (wr_valid) begin
      if (ncap < 64) begin cap_d[ncap] = wr_data; cap_fe[ncap] = frame_end; end
      ncap++;
    end
    if (frame_end) nfe++;
    s_busy = busy;
    s_fe   = frame_end;
    vld = v; sof = s; trig = t; din = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; vld = 0; sof = 0; trig = 0;
    repeat (2) @(negedge clk);
    // R1: outputs while reset applied
    chk(!busy && !wr_valid && !frame_end && !frame_err, "R1",
        {busy, wr_valid, frame_end, frame_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: outputs after release
    chk(!busy && !wr_valid && !frame_end && !frame_err, "R1",
        {busy, wr_valid, frame_end, frame_err}, 0);
  endtask

  function automatic bit gap_after(input int mode, input int k);
    if (mode == 0 || k == BEATS-1) return 0;
    return (k % mode) == 0;
  endfunction

  task automatic run(input int mode, input int pre, input bit t_arm, input bit t_cap,
                     input bit t_done, input bit xsof);
    ncap = 0; nfe = 0;
    step(0, 0, 0, '0);
    step(0, 0, 1, '0);
    step(0, 0, 0, beat_word(3, 0));
    // R2: busy follows an idle trigger
    chk(s_busy == 1'b1, "R2", s_busy, 1);
    for (int j = 0; j < pre; j++) begin
      step(1, 0, t_arm && j == 0, beat_word(5, j));
      step(0, 1, 0, beat_word(6, j));
    end
    if (pre == 0 && t_arm) step(0, 0, 1, '0);
    // R3: nothing forwarded while armed without a valid start
    step(0, 0, 0, '0);
    chk(ncap == 0, "R3", ncap, 0);
    for (int k = 0; k < BEATS; k++) begin
      step(1, (k == 0) || (xsof && k == 3), t_cap && k == 2, beat_word(1, k));
      if (gap_after(mode, k)) step(0, k % 2, 0, beat_word(7, k));
    end
    step(0, 0, t_done, '0);
    // R7: completion cycle still busy, carries the frame end
    chk(s_busy && s_fe, "R7", {s_busy, s_fe}, 2'b11);
    step(0, 0, 0, '0);
    // R7/R8: idle right after completion, triggers while busy ignored
    chk(!s_busy, "R7", s_busy, 0);
    for (int k = 0; k < BEATS; k++) step(1, k == 0, 0, beat_word(2, k));
    step(0, 0, 0, '0);
    step(0, 0, 0, '0);
    // R5: exact beat count; R7/R8: no second capture
    chk(ncap == BEATS, "R5", ncap, BEATS);
    chk(!s_busy, "R8", s_busy, 0);
    // R6: one frame end
    chk(nfe == 1, "R6", nfe, 1);
    for (int k = 0; k < BEATS && k < ncap; k++) begin
      // R4 (k==0) and R10: data lane for lane
      chk(cap_d[k] == beat_word(1, k), k == 0 ? "R4" : "R10", cap_d[k], beat_word(1, k));
      chk(cap_fe[k] == (k == BEATS-1), "R6", cap_fe[k], k == BEATS-1);
    end
    // R9: sticky error only after a mid-capture start
    chk(frame_err == xsof, "R9", frame_err, xsof);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int m = 0; m < 5; m++)
      for (int p = 0; p < 3; p++)
        run(m, p, 0, 0, 0, 0);
    // R8: triggers in armed, capturing and completion states
    run(2, 1, 1, 1, 1, 0);
    run(0, 0, 1, 1, 1, 0);
    // R9: start-of-frame inside a capture
    run(3, 1, 0, 0, 0, 1);
    do_reset();
    run(1, 2, 0, 1, 0, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule